// File: doc/BRIEF.md
# Streaming Kleene-Star Reach Unit

This block takes two bit streams that are aligned one bit per input character, a marker stream and a character-class stream, and works on them one fixed-width block per clock. For every marker it marks each position that can be reached from it by stepping over zero or more consecutive characters of the class. The stepping is not done one character at a time. The block masks the markers down to those that lie on class characters, adds the class stream to them as one integer, and then cleans the sum with an XOR against the class stream and an OR with the original markers. A whole run of class characters is therefore resolved in a single step.

A stream longer than one block is fed as consecutive blocks, with the earliest characters first. The carry out of each block's addition is registered and fed into the next block, so a run that crosses a block boundary is resolved as though the whole stream were a single wide integer. A start-of-stream flag clears that carry. The result is registered and appears one cycle after the block that produced it. Transposing bytes into bit streams, building class streams and compiling patterns are done by other blocks.

Top module: `star_reach_stream`

## Requirements
- R1: For each accepted block, `out_reach` equals (((M & C) + C + k) ^ C) | M, where M and C are the block's marker and class inputs, the sum is truncated to BLK_W bits and k is the inter-block carry.
- R2: Bit j of every stream is character j. Bit 0 is the earliest character and the least significant bit of the addition, and the carry out of bit BLK_W-1 feeds bit 0 of the next accepted block.
- R3: A marker on a position that is not in the class stays set in the output but does not spread to any later position.
- R4: Every marker bit set in an accepted block is also set in that block's output, because zero occurrences of the class are allowed.
- R5: A run of class characters that starts at a marker and crosses one or more block boundaries is marked through to the first non-class position after the run, even if that position lies in a later block.
- R6: A block accepted with `in_sos` high is processed with a carry-in of zero, whatever earlier blocks produced.
- R7: A cycle with `in_sos` high and `in_valid` low clears the stored carry, so the next accepted block starts with no carry.
- R8: While `in_valid` is low, `out_reach` holds its value and the stored carry is unchanged, unless `in_sos` clears it as in R7.
- R9: `out_valid` is `in_valid` delayed by exactly one clock, and `out_reach` belongs to the block accepted on the previous clock.
- R10: Synchronous active-low reset sets `out_valid` and `out_reach` to zero and clears the stored carry.
- R11: With 8-bit blocks, the 33-character stream of markers `.1..............1....1......1....` and digit class `.1111....11..........1......11...` (written from position 0 on the left, padded with zeros to 40 bits) gives `.11111..........1....11.....111..`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A block is presented this cycle |
| in_sos | input | 1 | Start of stream: clear the inter-block carry |
| in_marker | input | BLK_W | Marker block, bit 0 is the earliest character |
| in_class | input | BLK_W | Character-class block, aligned with `in_marker` |
| out_valid | output | 1 | `out_reach` holds a fresh result |
| out_reach | output | BLK_W | Positions reachable from the markers |

## Verification
The bench compares every output against a walk that moves from one character to the next, so a reversed bit order, a missing mask, a missing final OR or a missing XOR each shows up as wrongly set or cleared bits right beside markers or runs. The carry gets the closest attention. A run that ends on the last bit of a block must light bit 0 of the next block, and that carry has to survive idle cycles but not a start-of-stream flag. A design that drops the carry cuts runs off at block edges. A design that fails to clear it leaks a spurious mark into the first character of a new stream. A design that updates it on idle cycles loses runs split by gaps in the input.

// File: rtl/srs_pkg.sv
// Package: shared definitions for the streaming Kleene-star reach unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package srs_pkg;

    // Adder structure chosen for the block-wide addition.
    typedef enum logic {
        ADD_FLAT      = 1'b0,   // one wide '+' left to synthesis
        ADD_SEGMENTED = 1'b1    // ripple of fixed-width segments
    } add_style_e;

    // Number of segments of width seg_w in a block of width blk_w.
    function automatic int unsigned seg_count(int unsigned blk_w, int unsigned seg_w);
        return blk_w / seg_w;
    endfunction

endpackage

// File: rtl/srs_block_adder.sv
// Module: block-wide adder with carry in and carry out.
// Computes {cout, sum} = a + b + cin over BLK_W bits. Bit 0 is least
// significant. With ADD_SEGMENTED, BLK_W must be a multiple of SEG_W.
module srs_block_adder
    import srs_pkg::*;
#(
    parameter int unsigned BLK_W = 128,
    parameter int unsigned SEG_W = 32,
    parameter add_style_e  STYLE = ADD_SEGMENTED
) (
    input  logic [BLK_W-1:0] a,
    input  logic [BLK_W-1:0] b,
    input  logic             cin,
    output logic [BLK_W-1:0] sum,
    output logic             cout
);

    localparam int unsigned NSEG = seg_count(BLK_W, SEG_W);

    generate
        if (STYLE == ADD_FLAT) begin : g_flat
            logic [BLK_W:0] wide;
            // Single wide addition.
            always_comb begin
                wide = {1'b0, a} + {1'b0, b} + {{BLK_W{1'b0}}, cin};
            end
            assign sum  = wide[BLK_W-1:0];
            assign cout = wide[BLK_W];
        end else begin : g_seg
            logic [NSEG:0] chain;
            assign chain[0] = cin;
            for (genvar s = 0; s < NSEG; s++) begin : g_part
                logic [SEG_W:0] part;
                // One segment, carry rippling to the next.
                always_comb begin
                    part = {1'b0, a[s*SEG_W +: SEG_W]}
                         + {1'b0, b[s*SEG_W +: SEG_W]}
                         + {{SEG_W{1'b0}}, chain[s]};
                end
                assign sum[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
                assign chain[s+1]            = part[SEG_W];
            end
            assign cout = chain[NSEG];
        end
    endgenerate

endmodule

// File: rtl/srs_carry_reg.sv
// Module: inter-block carry store.
// Holds the addition carry between accepted blocks. It supplies a zero
// carry to a block flagged start-of-stream and clears on a start-of-stream
// flag given without a block. Assumes a synchronous active-low reset.
module srs_carry_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sos,
    input  logic cout_next,
    output logic carry_use
);

    logic carry_q;

    // Carry seen by the current block.
    assign carry_use = in_sos ? 1'b0 : carry_q;

    // Store the carry of accepted blocks; clear on reset or a lone start flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (in_valid)
            carry_q <= cout_next;
        else if (in_sos)
            carry_q <= 1'b0;
    end

    a_r7_sos_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sos && !in_valid) |=> (carry_q == 1'b0));

    a_r8_carry_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sos && !in_valid) |=> $stable(carry_q));

    a_r10_carry_reset: assert property (@(posedge clk)
        !rst_n |=> (carry_q == 1'b0));

endmodule

// File: rtl/srs_star_combine.sv
// Module: cleanup stage after the addition.
// XORs the sum with the class stream to keep the positions the addition
// passed through, then ORs the original markers back in. Purely combinational.
module srs_star_combine #(
    parameter int unsigned BLK_W = 128
) (
    input  logic [BLK_W-1:0] marker,
    input  logic [BLK_W-1:0] cls,
    input  logic [BLK_W-1:0] sum,
    output logic [BLK_W-1:0] reach
);

    logic [BLK_W-1:0] swept;

    // Positions changed by the addition, plus the marks just past each run.
    always_comb begin
        swept = sum ^ cls;
        reach = swept | marker;
    end

endmodule

// File: rtl/star_reach_stream.sv
// Module: streaming Kleene-star reach unit, top level.
// Each accepted block yields the positions reachable from the markers by
// zero or more class characters. The carry is chained between blocks. The
// result is registered, with one cycle of latency. Assumes bit 0 is the
// earliest character and blocks arrive in stream order.
module star_reach_stream
    import srs_pkg::*;
#(
    parameter int unsigned BLK_W = 128,
    parameter int unsigned SEG_W = 32,
    parameter add_style_e  STYLE = ADD_SEGMENTED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sos,
    input  logic [BLK_W-1:0] in_marker,
    input  logic [BLK_W-1:0] in_class,
    output logic             out_valid,
    output logic [BLK_W-1:0] out_reach
);

    logic [BLK_W-1:0] live_mark;
    logic [BLK_W-1:0] sum;
    logic [BLK_W-1:0] reach;
    logic             cout;
    logic             carry_use;

    // Only markers that lie on class characters enter the addition.
    assign live_mark = in_marker & in_class;

    srs_block_adder #(
        .BLK_W (BLK_W),
        .SEG_W (SEG_W),
        .STYLE (STYLE)
    ) u_adder (
        .a    (live_mark),
        .b    (in_class),
        .cin  (carry_use),
        .sum  (sum),
        .cout (cout)
    );

    srs_carry_reg u_carry (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sos    (in_sos),
        .cout_next (cout),
        .carry_use (carry_use)
    );

    srs_star_combine #(
        .BLK_W (BLK_W)
    ) u_combine (
        .marker (in_marker),
        .cls    (in_class),
        .sum    (sum),
        .reach  (reach)
    );

    // Output register: capture the result of accepted blocks, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_reach <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_reach <= reach;
        end
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_reach_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_reach));

    a_r4_markers_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_reach & $past(in_marker)) == $past(in_marker)));

    a_r6_sos_clean_block: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sos && ((in_marker & in_class) == '0))
            |=> (out_reach == $past(in_marker)));

    a_r10_out_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_reach == '0)));

endmodule

// File: tb/test_star_reach_stream.sv
// Bench: exhaustive single-block sweep on 8-bit blocks, multi-block random
// streams, the worked example, and carry corner cases. Expected values come
// from a character-by-character walk of the markers.
module test_star_reach_stream;
    import srs_pkg::*;

    localparam int  W      = 8;
    localparam time CLK_P  = 10;
    localparam int  WD_MAX = 190000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_sos;
    logic [W-1:0] in_marker;
    logic [W-1:0] in_class;
    logic         out_valid;
    logic [W-1:0] out_reach;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic         rc;        // reference chain: reachable and on a class char
    logic [W-1:0] last_exp;

    star_reach_stream #(.BLK_W(W), .SEG_W(4), .STYLE(ADD_SEGMENTED)) i_star_reach_stream (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
        .in_marker(in_marker), .in_class(in_class),
        .out_valid(out_valid), .out_reach(out_reach)
    );

    always #(CLK_P/2) clk = ~clk;

    // Walk the markers one character at a time.
    function automatic logic [W:0] walk(input logic [W-1:0] m, input logic [W-1:0] c,
                                        input logic ch_in);
        logic [W-1:0] r;
        logic ch;
        ch = ch_in;
        for (int j = 0; j < W; j++) begin
            r[j] = m[j] | ch;
            ch   = r[j] & c[j];
        end
        return {ch, r};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one block, then check its result just after the next edge (R9).
    task automatic send(input string req, input logic s, input logic [W-1:0] m,
                        input logic [W-1:0] c);
        logic [W:0] w;
        @(negedge clk);
        in_valid = 1'b1; in_sos = s; in_marker = m; in_class = c;
        if (s) rc = 1'b0;
        w = walk(m, c, rc);
        rc = w[W];
        last_exp = w[W-1:0];
        @(posedge clk); #1;
        check({req, " valid R9"}, {7'b0, out_valid}, 8'd1);
        check(req, out_reach, last_exp);
    endtask

    // Idle cycle with junk on the data inputs (R8).
    task automatic idle(input logic s);
        @(negedge clk);
        in_valid = 1'b0; in_sos = s; in_marker = 8'h5A; in_class = 8'hFF;
        if (s) rc = 1'b0;
        @(posedge clk); #1;
        check("R8 idle valid", {7'b0, out_valid}, 8'd0);
        check("R8 idle hold", out_reach, last_exp);
    endtask

    function automatic logic [39:0] parse(input string t);
        logic [39:0] v = '0;
        for (int i = 0; i < t.len(); i++) v[i] = (t[i] == "1");
        return v;
    endfunction

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_MAX) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] em, ec, eo, got;
        rst_n = 1'b0; in_valid = 1'b0; in_sos = 1'b0; in_marker = '0; in_class = '0;
        rc = 1'b0; last_exp = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", {7'b0, out_valid}, 8'd0);
        check("R10 reset reach", out_reach, 8'd0);
        @(negedge clk); rst_n = 1'b1;

        // R10: no carry after reset; class at bit 0, no marker.
        send("R10 carry clear", 1'b0, 8'h00, 8'hFF);
        // R3: marker off class stays, no spread.
        send("R3 off-class marker", 1'b1, 8'b0000_0100, 8'b1111_0000);
        // R2: run to top bit carries into bit 0 of next block.
        send("R2 run to top", 1'b1, 8'b0100_0000, 8'b1100_0000);
        send("R2 carry into bit0", 1'b0, 8'h00, 8'h00);
        // R5: run spanning three blocks.
        send("R5 span a", 1'b1, 8'b1000_0000, 8'b1000_0000);
        send("R5 span b", 1'b0, 8'h00, 8'hFF);
        send("R5 span c", 1'b0, 8'h00, 8'b0000_0011);
        // R8: carry held across idle cycles.
        send("R8 pre", 1'b1, 8'b1000_0000, 8'b1000_0000);
        idle(1'b0);
        idle(1'b0);
        send("R8 carry kept", 1'b0, 8'h00, 8'h00);
        // R7: lone start flag clears carry.
        send("R7 pre", 1'b1, 8'b1000_0000, 8'b1000_0000);
        idle(1'b1);
        send("R7 carry cleared", 1'b0, 8'h00, 8'h01);
        // R6: start flag with block ignores pending carry.
        send("R6 pre", 1'b1, 8'b1000_0000, 8'b1000_0000);
        send("R6 sos block", 1'b1, 8'h00, 8'h0F);

        // R11: worked example, five blocks.
        em = parse(".1..............1....1......1....");
        ec = parse(".1111....11..........1......11...");
        eo = parse(".11111..........1....11.....111..");
        for (int b = 0; b < 5; b++) begin
            send("R11 example", (b == 0), em[b*8 +: 8], ec[b*8 +: 8]);
            got[b*8 +: 8] = out_reach;
        end
        check("R11 example low", got[7:0], eo[7:0]);
        check("R11 example b1", got[15:8], eo[15:8]);
        check("R11 example b2", got[23:16], eo[23:16]);
        check("R11 example b3", got[31:24], eo[31:24]);
        check("R11 example b4", got[39:32], eo[39:32]);

        // R1 R4: exhaustive single blocks, each a fresh stream.
        for (int m = 0; m < 256; m++)
            for (int c = 0; c < 256; c++)
                send("R1 sweep", 1'b1, m[7:0], c[7:0]);

        // R1 R5: random multi-block streams with random gaps.
        for (int s = 0; s < 400; s++) begin
            for (int b = 0; b < 6; b++) begin
                if ($urandom_range(3) == 0) idle(1'b0);
                send("R5 random stream", (b == 0), 8'($urandom), 8'($urandom | $urandom));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule